// File: doc/BRIEF.md
# Low-Power Partitioned Register File

This block is the register file of a two-issue VLIW core whose first pipeline stage fetches, decodes and reads registers, and whose second stage executes and writes back. Storage is split into two independent banks of NREG registers. Each bank serves NRD read ports and NWR write ports. Write port s of a bank belongs to issue slot s. Results written in a cycle are also forwarded to any read port of the same bank that asks for the same register in that cycle.

Two mechanisms cut switching power. The first is a runtime-programmable boundary. Every register whose index is below the boundary is a dummy. A dummy holds only short-lived values, so writes to it never reach storage, and reads of it are served only from the forwarding path. The second is address isolation. Each port keeps the last address it was enabled with and presents that held address to its decoder while idle, so idle decoders do not toggle. The block also reports, per cycle, how many of its ports made real accesses, dummy accesses, or no access.

Top module: `lp_regfile`

## Requirements
- R1: After reset every stored register is zero, the dummy boundary is zero and every port's held address is zero, so every idle read port returns zero and all usage goes to the idle count.
- R2: Read port p of bank b is index b*NRD+p and write port of issue slot s in bank b is index b*NWR+s, each port taking an AW-bit address slice and a DW-bit data slice at its index. A write to a non-dummy register is stored at the clock edge, and an enabled read returns the stored value combinationally.
- R3: An enabled read whose address matches an enabled write in the same bank and cycle returns the write data. When both slots write that register, slot 1 is forwarded and slot 1 is the value stored.
- R4: The two banks are independent: a write to register i of one bank never changes register i of the other.
- R5: A cfg_we pulse loads cfg_bound into the boundary from the next cycle on. A value at or above NREG makes every register a dummy, and zero turns the mechanism off.
- R6: A write to a register whose index is below the boundary is not stored, and the earlier contents survive.
- R7: An enabled read of a dummy register with no same-cycle matching write returns zero and raises rd_miss for that port. With a matching write it returns the write data and rd_miss stays low.
- R8: A read port that is not enabled keeps the address of its last enabled access and returns the current stored contents of that register.
- R9: use_real, use_dummy and use_idle count, over all read and write ports in the current cycle, the enabled ports at or above the boundary, the enabled ports below it, and the disabled ports; they always add up to the total port count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | NBANK*NRD | Read port enables |
| rd_addr | input | NBANK*NRD*AW | Read addresses, AW bits per port |
| rd_data | output | NBANK*NRD*DW | Read data, DW bits per port |
| rd_miss | output | NBANK*NRD | Dummy read found no forwarded value |
| wr_en | input | NBANK*NWR | Write port enables, one per issue slot per bank |
| wr_addr | input | NBANK*NWR*AW | Write addresses |
| wr_data | input | NBANK*NWR*DW | Write data, also the forwarding source |
| cfg_we | input | 1 | Load the dummy boundary |
| cfg_bound | input | AW+1 | New dummy boundary |
| use_real | output | CW | Ports making real accesses this cycle |
| use_dummy | output | CW | Ports making dummy accesses this cycle |
| use_idle | output | CW | Ports idle this cycle |

## Verification
The bench builds the block with its default parameters: two banks of 32 registers, 32-bit data, four read and two write ports per bank. These values bring the top register index 31, a boundary of 32 that covers the whole bank, and an oversized boundary of 45 within reach. The oversized value tells a saturating load apart from one that drops high bits. With twelve ports the usage counts can be checked as exact per-cycle values, and the bench uses two issue slots to write one register in the same cycle to check slot priority.

// File: rtl/lp_rf_pkg.sv
package lp_rf_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_REAL  = 2'd1,
    ACC_DUMMY = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e classify_access(input logic en, input logic below_bound);
    if (!en)
      return ACC_IDLE;
    else if (below_bound)
      return ACC_DUMMY;
    else
      return ACC_REAL;
  endfunction

endpackage

// File: rtl/lp_rf_iso.sv
module lp_rf_iso #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] dec_o
);

  logic [AW-1:0] held_q;
  logic [AW-1:0] held_d;

  always_comb begin
    held_d = held_q;
    if (en_i) held_d = addr_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)
      held_q <= '0;
    else if (en_i)
      held_q <= held_d;
  end

  assign dec_o = en_i ? addr_i : held_q;

endmodule

// File: rtl/lp_rf_usage.sv
module lp_rf_usage
  import lp_rf_pkg::*;
#(
  parameter int NP = 12,
  parameter int CW = 4
) (
  input  logic [NP-1:0] en_i,
  input  logic [NP-1:0] below_i,
  output logic [CW-1:0] real_o,
  output logic [CW-1:0] dummy_o,
  output logic [CW-1:0] idle_o
);

  always_comb begin
    real_o  = '0;
    dummy_o = '0;
    idle_o  = '0;
    for (int p = 0; p < NP; p++) begin
      unique case (classify_access(en_i[p], below_i[p]))
        ACC_REAL:  real_o  = real_o  + CW'(1);
        ACC_DUMMY: dummy_o = dummy_o + CW'(1);
        default:   idle_o  = idle_o  + CW'(1);
      endcase
    end
  end

endmodule

// File: rtl/lp_rf_bank.sv
module lp_rf_bank #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int NRD  = 4,
  parameter int NWR  = 2,
  localparam int AW  = $clog2(NREG),
  localparam int BW  = AW + 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [BW-1:0]     bound_i,
  input  logic [NRD-1:0]    rd_en_i,
  input  logic [NRD*AW-1:0] rd_dec_i,
  output logic [NRD*DW-1:0] rd_data_o,
  output logic [NRD-1:0]    rd_miss_o,
  input  logic [NWR-1:0]    wr_en_i,
  input  logic [NWR*AW-1:0] wr_dec_i,
  input  logic [NWR*DW-1:0] wr_data_i
);

  logic [DW-1:0]   mem_q [NREG];
  logic [NREG-1:0] row_we;
  logic [DW-1:0]   row_wd [NREG];

  // Commit path: later issue slot overrides earlier one, dummies are dropped.
  always_comb begin
    row_we = '0;
    for (int i = 0; i < NREG; i++) row_wd[i] = '0;
    for (int s = 0; s < NWR; s++) begin
      if (wr_en_i[s] && ({1'b0, wr_dec_i[s*AW +: AW]} >= bound_i)) begin
        row_we[wr_dec_i[s*AW +: AW]] = 1'b1;
        row_wd[wr_dec_i[s*AW +: AW]] = wr_data_i[s*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (row_we[i]) mem_q[i] <= row_wd[i];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [AW-1:0] ra;
    logic          fwd_hit;
    logic [DW-1:0] fwd_val;
    logic          dummy;
    logic [DW-1:0] data;
    logic          miss;

    assign ra    = rd_dec_i[r*AW +: AW];
    assign dummy = ({1'b0, ra} < bound_i);

    always_comb begin
      fwd_hit = 1'b0;
      fwd_val = '0;
      for (int s = 0; s < NWR; s++) begin
        if (wr_en_i[s] && (wr_dec_i[s*AW +: AW] == ra)) begin
          fwd_hit = 1'b1;
          fwd_val = wr_data_i[s*DW +: DW];
        end
      end
    end

    always_comb begin
      miss = 1'b0;
      if (!rd_en_i[r]) begin
        data = mem_q[ra];
      end else if (fwd_hit) begin
        data = fwd_val;
      end else if (dummy) begin
        data = '0;
        miss = 1'b1;
      end else begin
        data = mem_q[ra];
      end
    end

    assign rd_data_o[r*DW +: DW] = data;
    assign rd_miss_o[r]          = miss;
  end

endmodule

// File: rtl/lp_regfile.sv
module lp_regfile #(
  parameter int DW    = 32,
  parameter int NREG  = 32,
  parameter int NBANK = 2,
  parameter int NRD   = 4,
  parameter int NWR   = 2,
  localparam int AW   = $clog2(NREG),
  localparam int BW   = AW + 1,
  localparam int NRP  = NBANK * NRD,
  localparam int NWP  = NBANK * NWR,
  localparam int NP   = NRP + NWP,
  localparam int CW   = $clog2(NP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NRP-1:0]    rd_en,
  input  logic [NRP*AW-1:0] rd_addr,
  output logic [NRP*DW-1:0] rd_data,
  output logic [NRP-1:0]    rd_miss,
  input  logic [NWP-1:0]    wr_en,
  input  logic [NWP*AW-1:0] wr_addr,
  input  logic [NWP*DW-1:0] wr_data,
  input  logic              cfg_we,
  input  logic [BW-1:0]     cfg_bound,
  output logic [CW-1:0]     use_real,
  output logic [CW-1:0]     use_dummy,
  output logic [CW-1:0]     use_idle
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= '0;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Dummy boundary register, saturating at NREG.
  logic [BW-1:0] bound_q;
  logic [BW-1:0] bound_d;

  always_comb begin
    bound_d = bound_q;
    if (cfg_we)
      bound_d = (cfg_bound > BW'(NREG)) ? BW'(NREG) : cfg_bound;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)
      bound_q <= '0;
    else if (cfg_we)
      bound_q <= bound_d;
  end

  // Address isolation on every port.
  logic [NRP*AW-1:0] rd_dec;
  logic [NWP*AW-1:0] wr_dec;

  for (genvar p = 0; p < NRP; p++) begin : g_rd_iso
    lp_rf_iso #(.AW(AW)) u_iso (
      .clk    (clk),
      .rst_ni (rst_int_n),
      .en_i   (rd_en[p]),
      .addr_i (rd_addr[p*AW +: AW]),
      .dec_o  (rd_dec[p*AW +: AW])
    );
  end

  for (genvar q = 0; q < NWP; q++) begin : g_wr_iso
    lp_rf_iso #(.AW(AW)) u_iso (
      .clk    (clk),
      .rst_ni (rst_int_n),
      .en_i   (wr_en[q]),
      .addr_i (wr_addr[q*AW +: AW]),
      .dec_o  (wr_dec[q*AW +: AW])
    );
  end

  // Banks.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    lp_rf_bank #(
      .DW   (DW),
      .NREG (NREG),
      .NRD  (NRD),
      .NWR  (NWR)
    ) u_bank (
      .clk       (clk),
      .rst_ni    (rst_int_n),
      .bound_i   (bound_q),
      .rd_en_i   (rd_en[b*NRD +: NRD]),
      .rd_dec_i  (rd_dec[b*NRD*AW +: NRD*AW]),
      .rd_data_o (rd_data[b*NRD*DW +: NRD*DW]),
      .rd_miss_o (rd_miss[b*NRD +: NRD]),
      .wr_en_i   (wr_en[b*NWR +: NWR]),
      .wr_dec_i  (wr_dec[b*NWR*AW +: NWR*AW]),
      .wr_data_i (wr_data[b*NWR*DW +: NWR*DW])
    );
  end

  // Per-port classification for usage counting.
  logic [NRP-1:0] rd_below;
  logic [NWP-1:0] wr_below;

  for (genvar p = 0; p < NRP; p++) begin : g_rd_cls
    assign rd_below[p] = ({1'b0, rd_addr[p*AW +: AW]} < bound_q);
  end
  for (genvar q = 0; q < NWP; q++) begin : g_wr_cls
    assign wr_below[q] = ({1'b0, wr_addr[q*AW +: AW]} < bound_q);
  end

  lp_rf_usage #(.NP(NP), .CW(CW)) u_usage (
    .en_i    ({wr_en, rd_en}),
    .below_i ({wr_below, rd_below}),
    .real_o  (use_real),
    .dummy_o (use_dummy),
    .idle_o  (use_idle)
  );

endmodule

// File: rtl/lp_regfile_chk.sv
module lp_regfile_chk #(
  parameter int DW    = 32,
  parameter int NREG  = 32,
  parameter int NBANK = 2,
  parameter int NRD   = 4,
  parameter int NWR   = 2,
  localparam int AW   = $clog2(NREG),
  localparam int BW   = AW + 1,
  localparam int NRP  = NBANK * NRD,
  localparam int NP   = NRP + NBANK * NWR,
  localparam int CW   = $clog2(NP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NRP-1:0]    rd_en,
  input logic [NRP*DW-1:0] rd_data,
  input logic [NRP-1:0]    rd_miss,
  input logic [NRP*AW-1:0] rd_dec,
  input logic              cfg_we,
  input logic [BW-1:0]     bound_q,
  input logic [CW-1:0]     use_real,
  input logic [CW-1:0]     use_dummy,
  input logic [CW-1:0]     use_idle
);

  assert_usage_total_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(use_real) + int'(use_dummy) + int'(use_idle)) == NP);

  assert_miss_counted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_miss) |-> (use_dummy != '0));

  assert_bound_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bound_q <= BW'(NREG));

  assert_bound_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(bound_q));

  for (genvar p = 0; p < NRP; p++) begin : g_port
    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_miss[p] |-> (rd_data[p*DW +: DW] == '0));

    assert_miss_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_miss[p] |-> rd_en[p]);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[p] |=> (rd_en[p] || $stable(rd_dec[p*AW +: AW])));
  end

endmodule

bind lp_regfile lp_regfile_chk #(
  .DW    (DW),
  .NREG  (NREG),
  .NBANK (NBANK),
  .NRD   (NRD),
  .NWR   (NWR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .rd_miss   (rd_miss),
  .rd_dec    (rd_dec),
  .cfg_we    (cfg_we),
  .bound_q   (bound_q),
  .use_real  (use_real),
  .use_dummy (use_dummy),
  .use_idle  (use_idle)
);

// File: tb/sim_lp_regfile.sv
module sim_lp_regfile;

  localparam int DW  = 32;
  localparam int AW  = 5;
  localparam int NRD = 4;
  localparam int NWR = 2;
  localparam int NRP = 8;
  localparam int NWP = 4;

  typedef struct packed {
    logic        bank;
    logic        slot;
    logic [4:0]  addr;
    logic [1:0]  rport;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 5'd0,  2'd0, 32'h1111_0000},
    '{1'b0, 1'b1, 5'd31, 2'd1, 32'h2222_001F},
    '{1'b1, 1'b0, 5'd7,  2'd2, 32'h3333_0007},
    '{1'b1, 1'b1, 5'd12, 2'd3, 32'h4444_000C},
    '{1'b0, 1'b0, 5'd19, 2'd2, 32'h5555_0013},
    '{1'b1, 1'b1, 5'd31, 2'd0, 32'h6666_001F},
    '{1'b0, 1'b1, 5'd3,  2'd3, 32'h7777_0003},
    '{1'b1, 1'b0, 5'd25, 2'd1, 32'h8888_0019}
  };

  logic              clk;
  logic              rst_n;
  logic [NRP-1:0]    rd_en;
  logic [NRP*AW-1:0] rd_addr;
  logic [NRP*DW-1:0] rd_data;
  logic [NRP-1:0]    rd_miss;
  logic [NWP-1:0]    wr_en;
  logic [NWP*AW-1:0] wr_addr;
  logic [NWP*DW-1:0] wr_data;
  logic              cfg_we;
  logic [5:0]        cfg_bound;
  logic [3:0]        use_real;
  logic [3:0]        use_dummy;
  logic [3:0]        use_idle;

  int  n_chk;
  int  n_fail;
  bit  done;

  lp_regfile u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_miss   (rd_miss),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cfg_we    (cfg_we),
    .cfg_bound (cfg_bound),
    .use_real  (use_real),
    .use_dummy (use_dummy),
    .use_idle  (use_idle)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    rd_en  = '0;
    wr_en  = '0;
    cfg_we = 1'b0;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    quiet();
  endtask

  task automatic rd(input int p, input int a);
    rd_en[p] = 1'b1;
    rd_addr[p*AW +: AW] = a[4:0];
  endtask

  task automatic wr(input int q, input int a, input logic [31:0] d);
    wr_en[q] = 1'b1;
    wr_addr[q*AW +: AW] = a[4:0];
    wr_data[q*DW +: DW] = d;
  endtask

  function automatic logic [31:0] rdat(input int p);
    return rd_data[p*DW +: DW];
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    rd_addr = '0; wr_addr = '0; wr_data = '0; cfg_bound = '0;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state seen at the ports
    #1;
    for (int p = 0; p < NRP; p++) chk("R1 idle read after reset", rdat(p), 32'h0);
    chk("R1 no miss after reset", 32'(rd_miss), 32'h0);
    chk("R1 R9 idle count after reset", 32'(use_idle), 32'd12);
    chk("R1 R9 real count after reset", 32'(use_real), 32'd0);

    // Vector table: R3 forwarding in the write cycle, R2 storage next cycle
    for (int i = 0; i < 8; i++) begin
      next_cycle();
      wr(VEC[i].bank * NWR + VEC[i].slot, VEC[i].addr, VEC[i].data);
      rd(VEC[i].bank * NRD + VEC[i].rport, VEC[i].addr);
      #1;
      chk("R3 same-cycle forward", rdat(VEC[i].bank * NRD + VEC[i].rport), VEC[i].data);
      chk("R9 real count write+read", 32'(use_real), 32'd2);
      next_cycle();
      rd(VEC[i].bank * NRD + VEC[i].rport, VEC[i].addr);
      #1;
      chk("R2 stored value", rdat(VEC[i].bank * NRD + VEC[i].rport), VEC[i].data);
    end

    // R4: bank independence
    next_cycle();
    rd(0, 7); rd(4, 0); rd(5, 7);
    #1;
    chk("R4 bank0 reg7 untouched", rdat(0), 32'h0);
    chk("R4 bank1 reg0 untouched", rdat(4), 32'h0);
    chk("R4 bank1 reg7 kept", rdat(5), 32'h3333_0007);

    // R3: both slots hit one register
    next_cycle();
    wr(0, 10, 32'hAAAA_000A); wr(1, 10, 32'hBBBB_000A); rd(0, 10);
    #1;
    chk("R3 slot1 forward priority", rdat(0), 32'hBBBB_000A);
    next_cycle();
    rd(0, 10);
    #1;
    chk("R3 slot1 store priority", rdat(0), 32'hBBBB_000A);

    // R5: boundary load takes effect next cycle
    next_cycle();
    cfg_we = 1'b1; cfg_bound = 6'd4; rd(0, 0);
    #1;
    chk("R5 old boundary in load cycle", rdat(0), 32'h1111_0000);
    chk("R5 no miss in load cycle", 32'(rd_miss[0]), 32'h0);
    next_cycle();
    rd(0, 0); rd(1, 19);
    #1;
    chk("R7 dummy read returns zero", rdat(0), 32'h0);
    chk("R7 dummy read raises miss", 32'(rd_miss[0]), 32'h1);
    chk("R5 reg19 above boundary", rdat(1), 32'h5555_0013);
    chk("R9 dummy count", 32'(use_dummy), 32'd1);
    chk("R9 real count", 32'(use_real), 32'd1);
    chk("R9 idle count", 32'(use_idle), 32'd10);

    // R7: dummy read served by forwarding; R6 write dropped
    next_cycle();
    wr(0, 3, 32'hDEAD_0003); rd(2, 3);
    #1;
    chk("R7 dummy forwarded", rdat(2), 32'hDEAD_0003);
    chk("R7 no miss on forward", 32'(rd_miss[2]), 32'h0);
    chk("R9 dummy count write+read", 32'(use_dummy), 32'd2);
    next_cycle();
    cfg_we = 1'b1; cfg_bound = 6'd0;
    next_cycle();
    rd(3, 3);
    #1;
    chk("R6 dummy write not stored", rdat(3), 32'h7777_0003);
    chk("R5 zero boundary disables", 32'(rd_miss[3]), 32'h0);

    // R5: oversized boundary saturates to whole bank
    next_cycle();
    cfg_we = 1'b1; cfg_bound = 6'd45;
    next_cycle();
    rd(4, 31);
    #1;
    chk("R5 saturated boundary covers reg31", rdat(4), 32'h0);
    chk("R5 saturated boundary miss", 32'(rd_miss[4]), 32'h1);
    next_cycle();
    cfg_we = 1'b1; cfg_bound = 6'd0;
    next_cycle();
    rd(4, 31);
    #1;
    chk("R5 reg31 real again", rdat(4), 32'h6666_001F);

    // R8: address isolation on idle read ports
    next_cycle();
    rd(7, 12);
    #1;
    chk("R8 enabled read reg12", rdat(7), 32'h4444_000C);
    next_cycle();
    #1;
    chk("R8 idle port holds reg12", rdat(7), 32'h4444_000C);
    chk("R8 idle port holds reg7", rdat(6), 32'h3333_0007);
    next_cycle();
    wr(3, 12, 32'hCAFE_000C);
    #1;
    chk("R8 idle port before commit", rdat(7), 32'h4444_000C);
    next_cycle();
    #1;
    chk("R8 idle port tracks contents", rdat(7), 32'hCAFE_000C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule